// File: doc/BRIEF.md
# Descriptor Ring Index Manager

This block keeps track of one circular queue of fixed-size 16-byte descriptors held in memory. Software programs a base address, a ring length in elements and a limit index. The limit marks the first element software still owns, so hardware may consume only the elements from its own index up to, but not including, the limit. From these values the block offers a fetch request for a contiguous run of descriptors. The run is clipped so that it never passes the limit, never passes the last element of the ring, and never exceeds a burst cap set by a parameter.

When the consumer accepts a request, the hardware index moves past the fetched run. It returns to element 0 when the run ends at the ring's last element. A second index walks a status ring that has the same number of entries. For every completion pulse, the block emits one write address for that ring. Each status entry is 4 or 8 bytes wide, selected by an input sampled together with the completion. Bus transactions and the memory reads themselves belong to the surrounding logic.

Top module: `desc_ring_mgr`

## Requirements
- R1: While the asynchronous reset is held, and on the first cycle after it is released, `fetch_req_o` and `stat_wvalid_o` are 0. Reset clears the base registers, the ring length, the limit and both indices to 0.
- R2: While `fetch_req_o` is 1, `fetch_addr_o` equals the descriptor base plus 16 times the hardware index.
- R3: `fetch_req_o` is 1 exactly when the ring length is nonzero and the hardware index differs from the effective limit. With the index equal to the effective limit, the ring is empty and no request is made until software moves the limit.
- R4: `fetch_len_o` is the smallest of three values: MAX_BURST, the elements from the index up to the effective limit (counted around the wrap), and the elements from the index to the ring end.
- R5: A cycle with `fetch_req_o` and `fetch_ack_i` both 1 advances the hardware index by `fetch_len_o`. When the run ends at the last element, the index becomes 0. `fetch_ack_i` has no effect while `fetch_req_o` is 0.
- R6: A programmed limit equal to or larger than the ring length acts as a limit of 0.
- R7: Writing the ring length or the descriptor base sets the hardware index to 0. This takes priority over an acknowledge in the same cycle.
- R8: `cpl_i` high in a cycle makes `stat_wvalid_o` 1 in the next cycle, and only then. `stat_waddr_o` then equals the status base plus the status index times 8 when `stat_wide_i` was 1, or times 4 when it was 0, using the values current in the `cpl_i` cycle.
- R9: Each completion advances the status index by one, returning to 0 after the ring's last element. Writing the ring length or the status base sets the status index to 0, taking priority over a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_we_i | input | 1 | Load descriptor base |
| cfg_base_i | input | ADDR_W | Address of descriptor element 0 |
| cfg_size_we_i | input | 1 | Load ring length |
| cfg_size_i | input | IDX_W | Number of elements in the ring |
| cfg_limit_we_i | input | 1 | Load limit index |
| cfg_limit_i | input | IDX_W | First element still owned by software |
| cfg_sbase_we_i | input | 1 | Load status base |
| cfg_sbase_i | input | ADDR_W | Address of status element 0 |
| fetch_req_o | output | 1 | A descriptor run is available |
| fetch_addr_o | output | ADDR_W | Address of the first descriptor in the run |
| fetch_len_o | output | LEN_W | Number of descriptors in the run |
| fetch_ack_i | input | 1 | The run is accepted this cycle |
| cpl_i | input | 1 | One completion to record |
| stat_wide_i | input | 1 | 1: 8-byte status entries, 0: 4-byte |
| stat_wvalid_o | output | 1 | A status write address is presented |
| stat_waddr_o | output | ADDR_W | Status entry address |

## Verification
The fetch request, address and length are combinational from registered state. They are due in the same cycle as any register update that precedes them, so the bench compares them at the falling edge after each rising edge, before driving new inputs. The status write address comes one cycle after `cpl_i`. The bench's reference model therefore computes that expectation from the pre-edge status index, base and width, and compares it at the next falling edge. Configuration writes, acknowledges and completions are applied at a falling edge. The model advances its state exactly once per rising edge, so each expectation matches the register the design updates on that edge.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int unsigned DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int unsigned STAT_SHIFT_N = 2; // 4-byte status
  localparam int unsigned STAT_SHIFT_W = 3; // 8-byte status
endpackage

// File: rtl/ring_span_calc.sv
module ring_span_calc #(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned MAX_BURST = 8,
  parameter int unsigned LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic [IDX_W-1:0] limit_i,
  output logic             avail_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned SW = IDX_W + 1;
  localparam logic [SW-1:0] CAP = SW'(MAX_BURST);

  logic [IDX_W-1:0] lim_eff;
  logic [SW-1:0]    to_end, to_lim, run;

  always_comb begin
    lim_eff = (limit_i >= size_i) ? '0 : limit_i;
    to_end  = SW'(size_i) - SW'(idx_i);
    if (lim_eff == idx_i)     to_lim = '0;
    else if (lim_eff > idx_i) to_lim = SW'(lim_eff) - SW'(idx_i);
    else                      to_lim = to_end + SW'(lim_eff);
    run = (to_lim < to_end) ? to_lim : to_end;
    if (run > CAP) run = CAP;
    avail_o = (size_i != '0) && (to_lim != '0);
    len_o   = avail_o ? LEN_W'(run) : '0;
  end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        shift_sel_i, // 0:x4 1:x8 2:x16
  output logic [ADDR_W-1:0] addr_o
);
  import desc_ring_pkg::*;
  logic [ADDR_W-1:0] off;
  always_comb begin
    unique case (shift_sel_i)
      2'd0:    off = ADDR_W'(idx_i) << STAT_SHIFT_N;
      2'd1:    off = ADDR_W'(idx_i) << STAT_SHIFT_W;
      default: off = ADDR_W'(idx_i) << DESC_SHIFT;
    endcase
    addr_o = base_i + off;
  end
endmodule

// File: rtl/stat_ptr.sv
module stat_ptr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] size_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W:0] nxt;
  assign nxt = {1'b0, idx_o} + 1'b1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (clear_i) idx_o <= '0;
    else if (step_i)  idx_o <= (nxt >= {1'b0, size_i}) ? '0 : nxt[IDX_W-1:0];
  end
endmodule

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned MAX_BURST = 8,
  parameter int unsigned LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_base_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              cfg_size_we_i,
  input  logic [IDX_W-1:0]  cfg_size_i,
  input  logic              cfg_limit_we_i,
  input  logic [IDX_W-1:0]  cfg_limit_i,
  input  logic              cfg_sbase_we_i,
  input  logic [ADDR_W-1:0] cfg_sbase_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [LEN_W-1:0]  fetch_len_o,
  input  logic              fetch_ack_i,
  input  logic              cpl_i,
  input  logic              stat_wide_i,
  output logic              stat_wvalid_o,
  output logic [ADDR_W-1:0] stat_waddr_o
);
  logic [ADDR_W-1:0] base_q, sbase_q, saddr_d;
  logic [IDX_W-1:0]  size_q, limit_q, hw_idx_q, sidx;
  logic [IDX_W:0]    adv;
  logic              take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      sbase_q <= '0;
      size_q  <= '0;
      limit_q <= '0;
    end else begin
      if (cfg_base_we_i)  base_q  <= cfg_base_i;
      if (cfg_sbase_we_i) sbase_q <= cfg_sbase_i;
      if (cfg_size_we_i)  size_q  <= cfg_size_i;
      if (cfg_limit_we_i) limit_q <= cfg_limit_i;
    end
  end

  ring_span_calc #(.IDX_W(IDX_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) i_span (
    .idx_i(hw_idx_q), .size_i(size_q), .limit_i(limit_q),
    .avail_o(fetch_req_o), .len_o(fetch_len_o)
  );

  ring_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_faddr (
    .base_i(base_q), .idx_i(hw_idx_q), .shift_sel_i(2'd2), .addr_o(fetch_addr_o)
  );

  assign take = fetch_req_o && fetch_ack_i;
  assign adv  = {1'b0, hw_idx_q} + (IDX_W+1)'(fetch_len_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            hw_idx_q <= '0;
    else if (cfg_size_we_i || cfg_base_we_i) hw_idx_q <= '0;
    else if (take)
      hw_idx_q <= (adv >= {1'b0, size_q}) ? '0 : adv[IDX_W-1:0];
  end

  stat_ptr #(.IDX_W(IDX_W)) i_sptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(cfg_size_we_i || cfg_sbase_we_i),
    .step_i(cpl_i), .size_i(size_q), .idx_o(sidx)
  );

  ring_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_saddr (
    .base_i(sbase_q), .idx_i(sidx), .shift_sel_i({1'b0, stat_wide_i}), .addr_o(saddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_wvalid_o <= 1'b0;
      stat_waddr_o  <= '0;
    end else begin
      stat_wvalid_o <= cpl_i;
      if (cpl_i) stat_waddr_o <= saddr_d;
    end
  end
endmodule

// File: rtl/desc_ring_mgr_chk.sv
module desc_ring_mgr_chk #(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned MAX_BURST = 8,
  parameter int unsigned LEN_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_req_o,
  input logic [LEN_W-1:0] fetch_len_o,
  input logic             cfg_size_we_i,
  input logic             cfg_base_we_i,
  input logic             cpl_i,
  input logic             stat_wvalid_o,
  input logic [IDX_W-1:0] hw_idx_q,
  input logic [IDX_W-1:0] size_q
);
  // R1
  always_comb if (!rst_ni) rst_quiet_chk: assert (!fetch_req_o && !stat_wvalid_o);

  // R3
  empty_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q == '0) |-> !fetch_req_o);

  // R4
  burst_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (fetch_len_o != '0) && (int'(fetch_len_o) <= MAX_BURST));

  // R4
  ring_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (int'(hw_idx_q) + int'(fetch_len_o) <= int'(size_q)));

  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q != '0) |-> (hw_idx_q < size_q));

  // R7
  cfg_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_size_we_i || cfg_base_we_i) |=> (hw_idx_q == '0));

  // R8
  stat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_i |=> stat_wvalid_o);

  // R8
  stat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpl_i |=> !stat_wvalid_o);
endmodule

bind desc_ring_mgr desc_ring_mgr_chk #(
  .IDX_W(IDX_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
) i_desc_ring_mgr_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_req_o(fetch_req_o), .fetch_len_o(fetch_len_o),
  .cfg_size_we_i(cfg_size_we_i), .cfg_base_we_i(cfg_base_we_i), .cpl_i(cpl_i),
  .stat_wvalid_o(stat_wvalid_o), .hw_idx_q(hw_idx_q), .size_q(size_q)
);

// File: tb/test_desc_ring_mgr.sv
`timescale 1ns/1ps
module test_desc_ring_mgr;
  localparam int ADDR_W = 32, IDX_W = 8, MAX_BURST = 8, LEN_W = 4;

  logic clk = 0, rst_ni = 0;
  logic cfg_base_we = 0, cfg_size_we = 0, cfg_limit_we = 0, cfg_sbase_we = 0;
  logic [ADDR_W-1:0] cfg_base = 0, cfg_sbase = 0;
  logic [IDX_W-1:0] cfg_size = 0, cfg_limit = 0;
  logic fetch_ack = 0, cpl = 0, stat_wide = 0;
  logic fetch_req, stat_wvalid;
  logic [ADDR_W-1:0] fetch_addr, stat_waddr;
  logic [LEN_W-1:0] fetch_len;

  int checks = 0, errors = 0;
  int m_base, m_sbase, m_size, m_limit, m_idx, m_sidx;
  bit exp_sv; int exp_sa;

  always #2.5 clk = ~clk;

  desc_ring_mgr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAX_BURST(MAX_BURST)) i_desc_ring_mgr (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_base_we_i(cfg_base_we), .cfg_base_i(cfg_base),
    .cfg_size_we_i(cfg_size_we), .cfg_size_i(cfg_size),
    .cfg_limit_we_i(cfg_limit_we), .cfg_limit_i(cfg_limit),
    .cfg_sbase_we_i(cfg_sbase_we), .cfg_sbase_i(cfg_sbase),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_len_o(fetch_len),
    .fetch_ack_i(fetch_ack), .cpl_i(cpl), .stat_wide_i(stat_wide),
    .stat_wvalid_o(stat_wvalid), .stat_waddr_o(stat_waddr)
  );

  function automatic int lim_eff();
    return (m_limit >= m_size) ? 0 : m_limit;
  endfunction
  function automatic int to_lim();
    int l = lim_eff();
    if (l == m_idx) return 0;
    return (l > m_idx) ? l - m_idx : m_size - m_idx + l;
  endfunction
  function automatic bit exp_req();
    return (m_size != 0) && (to_lim() != 0);
  endfunction
  function automatic int exp_len();
    int r = to_lim();
    if (m_size - m_idx < r) r = m_size - m_idx;
    if (MAX_BURST < r) r = MAX_BURST;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit r = exp_req();
    chk("R3 fetch_req", int'(fetch_req), int'(r));
    if (r) begin
      chk("R2 fetch_addr", int'(fetch_addr), m_base + 16 * m_idx);
      chk("R4 fetch_len", int'(fetch_len), exp_len());
    end
    chk("R8 stat_wvalid", int'(stat_wvalid), int'(exp_sv));
    if (exp_sv) chk("R8/R9 stat_waddr", int'(stat_waddr), exp_sa);
  endtask

  // apply current inputs across one rising edge, update model, check at next falling edge
  task automatic step();
    bit r = exp_req();
    int l = exp_len();
    exp_sv = cpl;
    if (cpl) exp_sa = m_sbase + (stat_wide ? 8 : 4) * m_sidx;
    if (cfg_size_we || cfg_base_we) m_idx = 0;             // R7
    else if (r && fetch_ack) m_idx = (m_idx + l >= m_size) ? 0 : m_idx + l; // R5
    if (cfg_size_we || cfg_sbase_we) m_sidx = 0;          // R9
    else if (cpl) m_sidx = (m_sidx + 1 >= m_size) ? 0 : m_sidx + 1;
    if (cfg_base_we)  m_base  = int'(cfg_base);
    if (cfg_sbase_we) m_sbase = int'(cfg_sbase);
    if (cfg_size_we)  m_size  = int'(cfg_size);
    if (cfg_limit_we) m_limit = int'(cfg_limit);
    @(posedge clk); @(negedge clk);
    {cfg_base_we, cfg_size_we, cfg_limit_we, cfg_sbase_we, fetch_ack, cpl} = '0;
    check_outputs();
  endtask

  task automatic wr_size(int v);  cfg_size_we = 1;  cfg_size = IDX_W'(v);  endtask
  task automatic wr_limit(int v); cfg_limit_we = 1; cfg_limit = IDX_W'(v); endtask

  initial begin
    int seed = 17;
    void'($urandom(seed));
    m_base = 0; m_sbase = 0; m_size = 0; m_limit = 0; m_idx = 0; m_sidx = 0;
    exp_sv = 0; exp_sa = 0;
    #1;
    // R1
    chk("R1 req in reset", int'(fetch_req), 0);
    chk("R1 stat in reset", int'(stat_wvalid), 0);
    @(negedge clk); @(negedge clk); rst_ni = 1;
    @(posedge clk); @(negedge clk);
    check_outputs();

    // directed: base/size/limit, crossing burst cap, wrap at ring end
    cfg_base_we = 1; cfg_base = 32'h1000; cfg_sbase_we = 1; cfg_sbase = 32'h8000;
    wr_size(12); step();
    wr_limit(11); step();                    // R4 cap 8
    chk("R4 cap", int'(fetch_len), 8);
    fetch_ack = 1; step();                   // R5 idx 8
    chk("R5 advance addr", int'(fetch_addr), 32'h1000 + 16 * 8);
    chk("R4 to limit", int'(fetch_len), 3);
    fetch_ack = 1; step();                   // idx 11 == limit: empty
    chk("R3 empty", int'(fetch_req), 0);
    fetch_ack = 1; step();                   // R5 ack ignored while empty
    chk("R5 ack ignored", int'(fetch_addr), 32'h1000 + 16 * 11);
    wr_limit(4); step();                     // R4 run to ring end
    chk("R4 to end", int'(fetch_len), 1);
    fetch_ack = 1; step();                   // wraps to 0
    chk("R5 wrap", int'(fetch_addr), 32'h1000);
    chk("R4 after wrap", int'(fetch_len), 4);
    wr_limit(12); step();                    // R6 limit==size acts as 0
    chk("R6 limit=size", int'(fetch_req), 0);
    wr_limit(200); step();
    chk("R6 limit>size", int'(fetch_req), 0);
    wr_limit(5); step();
    fetch_ack = 1; wr_size(12); step();      // R7 size write beats ack
    chk("R7 rewind", int'(fetch_addr), 32'h1000);
    cpl = 1; stat_wide = 1; step();          // R8 wide
    chk("R8 wide addr", int'(stat_waddr), 32'h8000);
    cpl = 1; stat_wide = 0; step();
    chk("R8 narrow addr", int'(stat_waddr), 32'h8000 + 4);
    cfg_sbase_we = 1; cfg_sbase = 32'h9000; cpl = 1; step(); // R9 clear
    cpl = 1; step();
    chk("R9 clear", int'(stat_waddr), 32'h9000);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int p = $urandom_range(0, 99);
      if (p < 3) wr_size($urandom_range(0, 20));
      else if (p < 5) begin cfg_base_we = 1; cfg_base = 32'h1000 * $urandom_range(1, 15); end
      else if (p < 7) begin cfg_sbase_we = 1; cfg_sbase = 32'h100 * $urandom_range(1, 255); end
      if ($urandom_range(0, 99) < 20) wr_limit($urandom_range(0, 24));
      fetch_ack = ($urandom_range(0, 2) != 0);
      cpl = ($urandom_range(0, 2) == 0);
      stat_wide = $urandom_range(0, 1) != 0;
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule